// File: doc/BRIEF.md
# SPI Serial Memory Slave Front End

This block is the serial side of a memory device that answers as an SPI slave in mode 0. It runs on a fast system clock and brings chip select, serial clock, serial input and the pause pin into that domain through synchronizer chains. It assembles bytes most significant bit first. The first byte after select is checked against a fixed set of command codes. Decoded commands, addresses and incoming data bytes go to a back-end port. Outgoing bytes are fetched from the back end one at a time and shifted onto the serial output, which has its own output-enable for an external tri-state pad.

A code outside the set locks the interface: no input is taken and the output enable stays off until the select line falls again. Pulling the pause pin low while the serial clock is low freezes the transfer in place. Serial clock edges are then ignored and the output pad is released. Raising the pin while the clock is low resumes the transfer exactly where it stopped. Write-type commands are reported to the back end at the end of the frame, and only when at least one whole data byte arrived.

Top module: `spi_mem_front`

## Requirements
- R1: After reset, so_oe_o is 0 and neither cmd_valid_o nor wr_byte_valid_o is asserted.
- R2: Opcode, address and data bytes are assembled from si_i most significant bit first, sampled on the sck_i rising edge; output bytes leave on so_o most significant bit first, changing on the sck_i falling edge.
- R3: The first byte after cs_ni falls is the opcode. The accepted codes and their cmd_o values are: 06h gives 1, 04h gives 2, 05h gives 3, 01h gives 4, 03h gives 5, 02h gives 6. Codes 06h and 04h are reported with a one-cycle cmd_valid_o pulse as soon as the opcode byte completes.
- R4: Any other opcode locks the frame: no command, no data byte and no output enable until the next cs_ni falling edge.
- R5: A cs_ni falling edge restarts opcode reception from bit 0, including after a lock or an abandoned partial frame.
- R6: While cs_ni is high, sck_i and si_i have no effect and so_oe_o is 0.
- R7: For opcode 03h, two address bytes follow (high byte first). At the end of the address, cmd_valid_o pulses with cmd_o=5 and addr_o holding the address. From then on, each completed byte pulses tx_req_o, and the tx_byte_i value present on the next clock is sent as the following output byte, with so_oe_o asserted.
- R8: For opcode 05h, cmd_valid_o pulses with cmd_o=3 after the opcode, and output bytes follow at once, as in R7.
- R9: For opcode 02h (after a two-byte address) and opcode 01h, each completed data byte pulses wr_byte_valid_o with the byte on wr_byte_o. When cs_ni rises, cmd_valid_o pulses with cmd_o=6 (addr_o = address) or cmd_o=4 (addr_o = 0), but only if at least one full data byte arrived.
- R10: A partial byte in progress when cs_ni rises is discarded and produces no wr_byte_valid_o.
- R11: hold_ni low while sck_i is low pauses the transfer. sck_i and si_i are then ignored and so_oe_o is 0. hold_ni high while sck_i is low resumes the transfer with the bit position and shift contents kept.
- R12: A hold_ni low pulse that starts and ends while sck_i is high has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock from the master |
| si_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Pause request, active low |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for the so_o pad |
| cmd_valid_o | output | 1 | One-cycle command report pulse |
| cmd_o | output | 3 | Command code (R3 encoding) |
| addr_o | output | 8*ADDR_BYTES | Address of the reported command |
| wr_byte_valid_o | output | 1 | One-cycle pulse per received data byte |
| wr_byte_o | output | 8 | Received data byte |
| tx_req_o | output | 1 | Request for the next output byte |
| tx_byte_i | input | 8 | Next output byte, sampled the cycle after tx_req_o |

## Verification
The bench builds the block with ADDR_BYTES=2 and SYNC_STAGES=2. That puts the full two-byte address framing of reads and writes in reach, along with the three-cycle input latency that each check is timed around. The serial clock runs at one sixteenth of the system clock. This leaves room to hold the pause pin across serial clock toggles, and to drop and release it inside a single high phase, so both the accepted and the ignored pause cases are exercised.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_WDATA, ST_RDATA, ST_SINK, ST_LOCK
  } st_e;

  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_WREN  = 3'd1,
    CMD_WRDI  = 3'd2,
    CMD_RDSR  = 3'd3,
    CMD_WRSR  = 3'd4,
    CMD_READ  = 3'd5,
    CMD_WRITE = 3'd6
  } cmd_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= stg[g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_s_i,
  input  logic sck_s_i,
  input  logic hold_n_s_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic held_o
);
  logic sck_prev;
  logic held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_prev <= 1'b0;
      held_q   <= 1'b0;
    end else begin
      sck_prev <= sck_s_i;
      if (cs_n_s_i)      held_q <= 1'b0;
      else if (!sck_s_i) held_q <= !hold_n_s_i;  // pause changes only with sck low
    end
  end

  assign sck_rise_o = sck_s_i & ~sck_prev & ~held_q & ~cs_n_s_i;
  assign sck_fall_o = ~sck_s_i & sck_prev & ~held_q & ~cs_n_s_i;
  assign held_o     = held_q;
endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
  import spi_mem_pkg::*;
#(
  parameter int ADDR_BYTES = 2,
  localparam int ADDR_W = 8 * ADDR_BYTES,
  localparam int BC_W   = $clog2(BYTE_W),
  localparam int AC_W   = $clog2(ADDR_BYTES) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_s_i,
  input  logic              si_s_i,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic [7:0]        tx_byte_i,
  output st_e               state_o,
  output logic [BC_W-1:0]   bit_cnt_o,
  output logic              cmd_valid_o,
  output cmd_e              cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_valid_o,
  output logic [7:0]        wr_byte_o,
  output logic              tx_req_o,
  output logic              so_o,
  output logic              out_phase_o
);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(BYTE_W - 1);
  localparam logic [AC_W-1:0] LAST_AB  = AC_W'(ADDR_BYTES - 1);

  st_e               state;
  cmd_e              cmd_q;
  logic [BC_W-1:0]   bit_cnt;
  logic [AC_W-1:0]   acnt;
  logic [7:0]        sh, tx_sh;
  logic [ADDR_W-1:0] addr_q;
  logic              cs_prev, data_seen, out_phase, so_q;
  logic              cmd_valid_q, wr_valid_q, tx_req_q;
  logic [7:0]        wr_byte_q;

  logic [7:0]          sh_nx;
  logic [ADDR_W+7:0]   addr_cat;
  logic                shifting;

  assign sh_nx    = {sh[6:0], si_s_i};
  assign addr_cat = {addr_q, sh_nx};
  assign shifting = (state == ST_OPC) || (state == ST_ADDR) ||
                    (state == ST_WDATA) || (state == ST_RDATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE; cmd_q <= CMD_NONE; bit_cnt <= '0; acnt <= '0;
      sh <= '0; tx_sh <= '0; addr_q <= '0; cs_prev <= 1'b1;
      data_seen <= 1'b0; out_phase <= 1'b0; so_q <= 1'b0;
      cmd_valid_q <= 1'b0; wr_valid_q <= 1'b0; tx_req_q <= 1'b0; wr_byte_q <= '0;
    end else begin
      cmd_valid_q <= 1'b0;
      wr_valid_q  <= 1'b0;
      tx_req_q    <= 1'b0;
      cs_prev     <= cs_n_s_i;
      if (tx_req_q) tx_sh <= tx_byte_i;  // back end answers one cycle after request
      if (cs_n_s_i) begin
        if (!cs_prev && state == ST_WDATA && data_seen) cmd_valid_q <= 1'b1;
        state <= ST_IDLE;
        out_phase <= 1'b0;
      end else if (cs_prev) begin
        state <= ST_OPC; bit_cnt <= '0; acnt <= '0;
        data_seen <= 1'b0; out_phase <= 1'b0;
      end else begin
        if (sck_rise_i && shifting) begin
          sh <= sh_nx;
          bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
          if (bit_cnt == LAST_BIT) begin
            unique case (state)
              ST_OPC: begin
                unique case (sh_nx)
                  OP_WREN:  begin cmd_q <= CMD_WREN; cmd_valid_q <= 1'b1; state <= ST_SINK; end
                  OP_WRDI:  begin cmd_q <= CMD_WRDI; cmd_valid_q <= 1'b1; state <= ST_SINK; end
                  OP_RDSR:  begin cmd_q <= CMD_RDSR; cmd_valid_q <= 1'b1; tx_req_q <= 1'b1;
                                  state <= ST_RDATA; end
                  OP_WRSR:  begin cmd_q <= CMD_WRSR; addr_q <= '0; state <= ST_WDATA; end
                  OP_READ:  begin cmd_q <= CMD_READ; state <= ST_ADDR; end
                  OP_WRITE: begin cmd_q <= CMD_WRITE; state <= ST_ADDR; end
                  default:  state <= ST_LOCK;
                endcase
              end
              ST_ADDR: begin
                addr_q <= addr_cat[ADDR_W-1:0];
                acnt   <= acnt + 1'b1;
                if (acnt == LAST_AB) begin
                  if (cmd_q == CMD_READ) begin
                    cmd_valid_q <= 1'b1; tx_req_q <= 1'b1; state <= ST_RDATA;
                  end else begin
                    state <= ST_WDATA;
                  end
                end
              end
              ST_WDATA: begin
                wr_valid_q <= 1'b1; wr_byte_q <= sh_nx; data_seen <= 1'b1;
              end
              ST_RDATA: tx_req_q <= 1'b1;
              default: ;
            endcase
          end
        end
        if (sck_fall_i && state == ST_RDATA) begin
          so_q      <= tx_sh[7];
          tx_sh     <= {tx_sh[6:0], 1'b0};
          out_phase <= 1'b1;
        end
      end
    end
  end

  assign state_o     = state;
  assign bit_cnt_o   = bit_cnt;
  assign cmd_valid_o = cmd_valid_q;
  assign cmd_o       = cmd_q;
  assign addr_o      = addr_q;
  assign wr_valid_o  = wr_valid_q;
  assign wr_byte_o   = wr_byte_q;
  assign tx_req_o    = tx_req_q;
  assign so_o        = so_q;
  assign out_phase_o = out_phase;
endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front
  import spi_mem_pkg::*;
#(
  parameter int ADDR_BYTES  = 2,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = 8 * ADDR_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              si_i,
  input  logic              hold_ni,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              cmd_valid_o,
  output logic [2:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_byte_valid_o,
  output logic [7:0]        wr_byte_o,
  output logic              tx_req_o,
  input  logic [7:0]        tx_byte_i
);
  localparam int BC_W = $clog2(BYTE_W);

  logic [3:0] pins_s;
  logic cs_n_s, sck_s, si_s, hold_n_s;
  logic sck_rise, sck_fall, held, out_phase;
  st_e  state;
  cmd_e cmd;
  logic [BC_W-1:0] bit_cnt;

  // order: cs, sck, si, hold; idle levels on reset
  spi_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk_i, .rst_ni, .d_i({cs_ni, sck_i, si_i, hold_ni}), .q_o(pins_s)
  );
  assign {cs_n_s, sck_s, si_s, hold_n_s} = pins_s;

  spi_hold_gate u_hold (
    .clk_i, .rst_ni, .cs_n_s_i(cs_n_s), .sck_s_i(sck_s), .hold_n_s_i(hold_n_s),
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall), .held_o(held)
  );

  spi_cmd_fsm #(.ADDR_BYTES(ADDR_BYTES)) u_fsm (
    .clk_i, .rst_ni, .cs_n_s_i(cs_n_s), .si_s_i(si_s),
    .sck_rise_i(sck_rise), .sck_fall_i(sck_fall), .tx_byte_i,
    .state_o(state), .bit_cnt_o(bit_cnt),
    .cmd_valid_o, .cmd_o(cmd), .addr_o,
    .wr_valid_o(wr_byte_valid_o), .wr_byte_o,
    .tx_req_o, .so_o, .out_phase_o(out_phase)
  );

  assign cmd_o   = cmd;
  assign so_oe_o = out_phase & ~held & ~cs_n_s;
endmodule

// File: rtl/spi_mem_front_chk.sv
module spi_mem_front_chk
  import spi_mem_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_n_s,
  input logic       held,
  input st_e        state,
  input logic [2:0] bit_cnt,
  input logic       so_oe_o,
  input logic       cmd_valid_o,
  input logic       wr_byte_valid_o
);
  // R6
  p_oe_off_deselected_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s |-> !so_oe_o);
  // R11
  p_oe_off_held_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held |-> !so_oe_o);
  p_hold_freezes_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held && $past(held) && !cs_n_s && !$past(cs_n_s)) |-> $stable(bit_cnt));
  // R4
  p_lock_silent_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_LOCK) |-> (!so_oe_o && !wr_byte_valid_o && !cmd_valid_o));
  p_lock_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state) == ST_LOCK && !$past(cs_n_s) && !cs_n_s) |-> (state == ST_LOCK));
  // R3
  p_cmd_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
  // R9
  p_one_report_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_valid_o, wr_byte_valid_o}));
endmodule

bind spi_mem_front spi_mem_front_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_n_s(cs_n_s), .held(held), .state(state),
  .bit_cnt(bit_cnt), .so_oe_o(so_oe_o), .cmd_valid_o(cmd_valid_o),
  .wr_byte_valid_o(wr_byte_valid_o)
);

// File: tb/spi_mem_front_test.sv
module spi_mem_front_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe, cmd_valid, wr_valid, tx_req;
  logic [2:0] cmd;
  logic [15:0] addr;
  logic [7:0] wr_byte, tx_byte;

  int n_chk = 0, n_err = 0;
  int ev_n = 0, wr_n = 0, tx_cnt = 0;
  logic [2:0]  ev_cmd;
  logic [15:0] ev_addr;
  logic [7:0]  wr_log [16];
  logic oe_seen = 1'b0;

  always #2 clk = ~clk;

  spi_mem_front uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si), .hold_ni(hold_n),
    .so_o(so), .so_oe_o(so_oe), .cmd_valid_o(cmd_valid), .cmd_o(cmd), .addr_o(addr),
    .wr_byte_valid_o(wr_valid), .wr_byte_o(wr_byte), .tx_req_o(tx_req), .tx_byte_i(tx_byte)
  );

  assign tx_byte = 8'h5A + tx_cnt[7:0];

  always @(negedge clk) begin
    if (cmd_valid) begin ev_n++; ev_cmd = cmd; ev_addr = addr; end
    if (wr_valid) begin wr_log[wr_n % 16] = wr_byte; wr_n++; end
    if (tx_req) tx_cnt++;
    if (so_oe) oe_seen = 1'b1;
  end

  task automatic wait_c(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic cs_begin();
    cs_n = 1'b0; wait_c(8);
  endtask

  task automatic cs_end();
    wait_c(8); cs_n = 1'b1; wait_c(12);
  endtask

  // hmode 1: pause with sck low before bit hpos; hmode 2: hold pulse inside sck high of bit hpos
  task automatic xfer(input logic [7:0] tx, input int hpos, input int hmode,
                      output logic [7:0] rx, output logic oe_ok, output logic held_oe);
    oe_ok = 1'b1; held_oe = 1'b0; rx = '0;
    for (int i = 7; i >= 0; i--) begin
      if (hmode == 1 && 7 - i == hpos) begin
        hold_n = 1'b0; wait_c(8);
        if (so_oe) held_oe = 1'b1;
        for (int k = 0; k < 3; k++) begin
          sck = 1'b1; si = ~si; wait_c(4);
          if (so_oe) held_oe = 1'b1;
          sck = 1'b0; wait_c(4);
        end
        wait_c(4); hold_n = 1'b1; wait_c(8);
      end
      si = tx[i]; wait_c(8);
      rx[i] = so;
      if (!so_oe) oe_ok = 1'b0;
      sck = 1'b1;
      if (hmode == 2 && 7 - i == hpos) begin
        wait_c(2); hold_n = 1'b0; wait_c(6); hold_n = 1'b1; wait_c(8);
      end else begin
        wait_c(8);
      end
      sck = 1'b0;
    end
  endtask

  task automatic sb(input logic [7:0] tx);
    logic [7:0] r; logic a, b;
    xfer(tx, 0, 0, r, a, b);
  endtask

  task automatic half_byte(input logic [3:0] tx);
    for (int i = 3; i >= 0; i--) begin
      si = tx[i]; wait_c(8); sck = 1'b1; wait_c(8); sck = 1'b0;
    end
  endtask

  // {opcode, expected report count, expected cmd_o}
  localparam logic [15:0] VEC [8] = '{
    {8'h06, 4'd1, 4'd1}, {8'h04, 4'd1, 4'd2}, {8'h05, 4'd1, 4'd3}, {8'h01, 4'd0, 4'd0},
    {8'h03, 4'd0, 4'd0}, {8'h02, 4'd0, 4'd0}, {8'hAB, 4'd0, 4'd0}, {8'h00, 4'd0, 4'd0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] rx; logic oe_ok, held_oe;
    int e0, w0, t0;
    wait_c(5);
    chk("R1", "so_oe after reset", so_oe, 0);
    chk("R1", "cmd_valid after reset", cmd_valid, 0);
    chk("R1", "wr_valid after reset", wr_valid, 0);
    rst_n = 1'b1; wait_c(5);

    // R3 opcode table, opcode-only frames
    foreach (VEC[v]) begin
      e0 = ev_n;
      cs_begin(); sb(VEC[v][15:8]); cs_end();
      chk("R3", $sformatf("events op %h", VEC[v][15:8]), ev_n - e0, VEC[v][7:4]);
      if (VEC[v][7:4] == 4'd1) chk("R3", "cmd code", ev_cmd, VEC[v][3:0]);
    end

    // R7 / R2 read
    e0 = ev_n; t0 = tx_cnt;
    cs_begin(); sb(8'h03); sb(8'h12); sb(8'hC4);
    wait_c(4);
    chk("R7", "read reported", ev_n - e0, 1);
    chk("R7", "read cmd", ev_cmd, 5);
    chk("R2", "read address msb first", ev_addr, 16'h12C4);
    xfer(8'h00, 0, 0, rx, oe_ok, held_oe);
    chk("R7", "read byte 1", rx, 8'(8'h5A + t0 + 1));
    chk("R7", "oe during read", oe_ok, 1);
    xfer(8'h00, 0, 0, rx, oe_ok, held_oe);
    chk("R2", "read byte 2 msb first", rx, 8'(8'h5A + t0 + 2));
    cs_end();
    chk("R6", "oe off after deselect", so_oe, 0);

    // R8 status read
    e0 = ev_n; t0 = tx_cnt;
    cs_begin(); sb(8'h05);
    xfer(8'h00, 0, 0, rx, oe_ok, held_oe);
    cs_end();
    chk("R8", "status cmd", ev_cmd, 3);
    chk("R8", "status byte", rx, 8'(8'h5A + t0 + 1));
    chk("R8", "status oe", oe_ok, 1);

    // R9 / R10 write with two data bytes and a partial one
    e0 = ev_n; w0 = wr_n;
    cs_begin(); sb(8'h02); sb(8'h0A); sb(8'hBC); sb(8'h96); sb(8'h3E); half_byte(4'hF);
    wait_c(4);
    chk("R9", "write not reported before cs rise", ev_n - e0, 0);
    cs_end();
    chk("R9", "write reported", ev_n - e0, 1);
    chk("R9", "write cmd", ev_cmd, 6);
    chk("R9", "write addr", ev_addr, 16'h0ABC);
    chk("R10", "partial byte dropped", wr_n - w0, 2);
    chk("R2", "data byte 1", wr_log[w0 % 16], 8'h96);
    chk("R9", "data byte 2", wr_log[(w0 + 1) % 16], 8'h3E);

    // R9 write without data
    e0 = ev_n;
    cs_begin(); sb(8'h02); sb(8'h00); sb(8'h10); half_byte(4'h5); cs_end();
    chk("R9", "write without data unreported", ev_n - e0, 0);

    // R9 status write
    e0 = ev_n; w0 = wr_n;
    cs_begin(); sb(8'h01); sb(8'h8C); cs_end();
    chk("R9", "wrsr reported", ev_n - e0, 1);
    chk("R9", "wrsr cmd", ev_cmd, 4);
    chk("R9", "wrsr addr zero", ev_addr, 0);
    chk("R9", "wrsr byte", wr_log[w0 % 16], 8'h8C);

    // R4 lock then R5 recovery
    e0 = ev_n; w0 = wr_n; oe_seen = 1'b0;
    cs_begin(); sb(8'hFF); sb(8'h02); sb(8'h00); sb(8'h00); sb(8'h55); sb(8'h06);
    chk("R4", "no report while locked", ev_n - e0, 0);
    chk("R4", "no data while locked", wr_n - w0, 0);
    chk("R4", "oe never on while locked", oe_seen, 0);
    cs_n = 1'b1; wait_c(12);
    cs_begin(); sb(8'h06); cs_end();
    chk("R5", "recover after lock", ev_n - e0, 1);
    chk("R5", "recover cmd", ev_cmd, 1);

    // R6 deselected activity
    e0 = ev_n; oe_seen = 1'b0;
    sb(8'h06); sb(8'h05);
    chk("R6", "no report while deselected", ev_n - e0, 0);
    chk("R6", "oe off while deselected", oe_seen, 0);

    // R5 abandoned partial frame restarts at bit 0
    cs_begin(); half_byte(4'hA); cs_n = 1'b1; wait_c(12);
    cs_begin(); sb(8'h04); cs_end();
    chk("R5", "restart after partial", ev_n - e0, 1);
    chk("R5", "restart cmd", ev_cmd, 2);

    // R11 pause mid-byte on read and write
    t0 = tx_cnt;
    cs_begin(); sb(8'h03); sb(8'h00); sb(8'h40);
    xfer(8'h00, 4, 1, rx, oe_ok, held_oe);
    chk("R11", "oe off while held", held_oe, 0);
    chk("R11", "read byte across hold", rx, 8'(8'h5A + t0 + 1));
    cs_end();
    w0 = wr_n;
    cs_begin(); sb(8'h02); sb(8'h01); sb(8'h02);
    xfer(8'hC3, 3, 1, rx, oe_ok, held_oe);
    cs_end();
    chk("R11", "write byte across hold", wr_log[w0 % 16], 8'hC3);
    chk("R11", "write count across hold", wr_n - w0, 1);

    // R12 hold pulse within sck high
    w0 = wr_n;
    cs_begin(); sb(8'h02); sb(8'h01); sb(8'h02);
    xfer(8'h69, 5, 2, rx, oe_ok, held_oe);
    cs_end();
    chk("R12", "byte after high-phase hold pulse", wr_log[w0 % 16], 8'h69);
    chk("R12", "count after high-phase hold pulse", wr_n - w0, 1);

    finish_run();
  end
endmodule